// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table that lives in ordinary memory. A requester presents the virtual address and an access-type tag on a valid/ready handshake. The block computes the address of the directory entry from its table-root register, reads that word over a simple request/response memory port, and then does the same for the leaf entry if the directory entry is present. It returns the physical address and the leaf's permission flags, or a fault code, together with a one-cycle done pulse.

The table-root register is loaded by software through a write strobe, typically on a context switch. Each walk takes a copy of the root when it is accepted, so a change affects only later walks. The memory port may answer after any number of cycles, and the walker waits in each read for the response.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: A request is accepted only on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the walk ends, and `req_valid` held during a walk starts no second walk.
- R3: The first read goes to the root value plus four times the directory index, which is virtual address bits 31:22.
- R4: The second read goes to the directory entry's frame (entry bits 31:12, followed by 12 zero bits) plus four times the leaf index, which is virtual address bits 21:12.
- R5: If the directory entry's present bit (bit 0) is 0, the walk ends with fault code 1 after exactly one read.
- R6: If the leaf entry's present bit (bit 0) is 0, the walk ends with fault code 2 after exactly two reads.
- R7: On success the fault code is 0, `paddr` is leaf bits 31:12 followed by virtual address bits 11:0, and `perm` is {bit 3 execute, bit 2 user, bit 1 writable} of the leaf. Entry bits 11:4 have no effect.
- R8: A root write takes effect for walks accepted after the write's cycle. A write in the accepting cycle or during a walk leaves that walk's addresses unchanged.
- R9: The walker waits in each read for `mem_rsp_valid`, whatever the latency.
- R10: `done` is high for exactly one cycle per walk, with `fault`, `paddr`, `perm` and `res_kind` (the request's access tag) valid in that cycle. On a fault `paddr` and `perm` are zero.
- R11: Virtual address 0x05EAE864 splits into directory index 0x017, leaf index 0x2AE and offset 0x864.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_we | input | 1 | Load strobe for the table-root register |
| root_wdata | input | 32 | New table-root byte address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access-type tag, returned with the result |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word read |
| done | output | 1 | One-cycle result strobe |
| fault | output | 2 | 0 none, 1 directory entry absent, 2 leaf absent |
| paddr | output | 32 | Physical address |
| perm | output | 3 | Leaf flags {execute, user, writable} |
| res_kind | output | 2 | Access tag of the finished request |

## Verification
The read request appears in the cycle after acceptance, and again in the cycle after the directory response is taken; `done` rises in the cycle after the final response is taken, one response earlier on a directory fault. The bench therefore never predicts a fixed cycle for `done`: its memory model answers each read after one to three cycles, and the bench samples on falling edges, polling until `done` is seen, then checks all result ports in that cycle and checks that `done` has fallen one cycle later. The read count and both read addresses are recorded by the memory model at the falling edge where `mem_req_valid` is high.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    localparam int VA_W        = 32;
    localparam int OFF_W       = 12;
    localparam int LEVELS      = 2;
    localparam int IDX_W       = (VA_W - OFF_W) / LEVELS;
    localparam int ENTRY_BYTES = 4;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam int FRAME_W     = VA_W - OFF_W;
    localparam int KIND_W      = 2;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_DIR  = 2'd1,
        FLT_LEAF = 2'd2
    } fault_e;

    typedef struct packed {
        logic exec;
        logic user;
        logic wr;
    } perm_t;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [7:0]         rsvd;
        perm_t              perm;
        logic               present;
    } pte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WT,
        ST_LEAF_RD,
        ST_LEAF_WT,
        ST_DONE
    } wstate_e;

    function automatic logic [VA_W-1:0] entry_addr(input logic [VA_W-1:0] tbl,
                                                   input logic [IDX_W-1:0] idx);
        logic [VA_W-1:0] scaled;
        scaled = {{(VA_W-IDX_W){1'b0}}, idx} << ENTRY_SHIFT;
        return tbl + scaled;
    endfunction

    function automatic logic [VA_W-1:0] frame_base(input logic [FRAME_W-1:0] frame);
        return {frame, {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split
    import pt_walk_pkg::*;
(
    input  logic [VA_W-1:0]              vaddr,
    output logic [LEVELS-1:0][IDX_W-1:0] idx,
    output logic [OFF_W-1:0]             offset
);
    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        assign idx[g] = vaddr[VA_W-1-g*IDX_W -: IDX_W];
    end
    assign offset = vaddr[OFF_W-1:0];
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    rsp_valid,
    input  logic    entry_present,
    output wstate_e state
);
    wstate_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_DIR_RD;
            ST_DIR_RD:  nxt = ST_DIR_WT;
            ST_DIR_WT:  if (rsp_valid) nxt = entry_present ? ST_LEAF_RD : ST_DONE;
            ST_LEAF_RD: nxt = ST_LEAF_WT;
            ST_LEAF_WT: if (rsp_valid) nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter logic [31:0] ROOT_RST = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        root_we,
    input  logic [31:0] root_wdata,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_kind,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        done,
    output logic [1:0]  fault,
    output logic [31:0] paddr,
    output logic [2:0]  perm,
    output logic [1:0]  res_kind
);
    wstate_e                     state;
    logic [VA_W-1:0]             root_q;
    logic [VA_W-1:0]             tbl_q;
    logic [VA_W-1:0]             va_q;
    logic [KIND_W-1:0]           kind_q;
    logic [VA_W-1:0]             paddr_q;
    perm_t                       perm_q;
    fault_e                      fault_q;
    logic [LEVELS-1:0][IDX_W-1:0] idx;
    logic [OFF_W-1:0]            offset;
    pte_t                        pte;
    logic                        accept;
    logic                        dir_take;
    logic                        leaf_take;

    assign pte       = pte_t'(mem_rsp_data);
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign dir_take  = (state == ST_DIR_WT)  && mem_rsp_valid;
    assign leaf_take = (state == ST_LEAF_WT) && mem_rsp_valid;

    pt_va_split u_split (
        .vaddr  (va_q),
        .idx    (idx),
        .offset (offset)
    );

    pt_walk_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start         (accept),
        .rsp_valid     (mem_rsp_valid),
        .entry_present (pte.present),
        .state         (state)
    );

    assign mem_req_valid = (state == ST_DIR_RD) || (state == ST_LEAF_RD);
    assign mem_req_addr  = entry_addr(tbl_q, (state == ST_LEAF_RD) ? idx[1] : idx[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            root_q  <= ROOT_RST;
            tbl_q   <= '0;
            va_q    <= '0;
            kind_q  <= '0;
            paddr_q <= '0;
            perm_q  <= '0;
            fault_q <= FLT_NONE;
        end else begin
            if (root_we) root_q <= root_wdata;
            if (accept) begin
                tbl_q  <= root_q;
                va_q   <= req_vaddr;
                kind_q <= req_kind;
            end
            if (dir_take) begin
                if (pte.present) begin
                    tbl_q <= frame_base(pte.frame);
                end else begin
                    fault_q <= FLT_DIR;
                    paddr_q <= '0;
                    perm_q  <= '0;
                end
            end
            if (leaf_take) begin
                if (pte.present) begin
                    fault_q <= FLT_NONE;
                    paddr_q <= frame_base(pte.frame) | {{(VA_W-OFF_W){1'b0}}, offset};
                    perm_q  <= pte.perm;
                end else begin
                    fault_q <= FLT_LEAF;
                    paddr_q <= '0;
                    perm_q  <= '0;
                end
            end
        end
    end

    assign done     = (state == ST_DONE);
    assign fault    = fault_q;
    assign paddr    = paddr_q;
    assign perm     = perm_q;
    assign res_kind = kind_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        mem_req_valid,
    input logic [31:0] mem_req_addr,
    input logic        mem_rsp_valid,
    input logic [31:0] mem_rsp_data,
    input logic        done,
    input logic [1:0]  fault,
    input logic [31:0] paddr,
    input logic [2:0]  perm
);
    logic [2:0]  rd_cnt;
    logic [31:0] va_seen;
    logic [31:0] dir_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt   <= '0;
            va_seen  <= '0;
            dir_seen <= '0;
        end else begin
            if (req_valid && req_ready) begin
                rd_cnt  <= '0;
                va_seen <= req_vaddr;
            end else if (mem_req_valid) begin
                rd_cnt <= rd_cnt + 3'd1;
            end
            if (mem_rsp_valid && rd_cnt == 3'd1) dir_seen <= mem_rsp_data;
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_LEAF_ADDR: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && rd_cnt == 3'd1) |->
        mem_req_addr == ({dir_seen[31:12], 12'h000} + {20'h0, va_seen[21:12], 2'b00})); // R4
    AST_DIR_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (rst)
        (done && fault == 2'd1) |-> rd_cnt == 3'd1); // R5
    AST_TWO_READS: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 2'd1) |-> rd_cnt == 3'd2); // R6
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (done && fault == 2'd0) |-> paddr[11:0] == va_seen[11:0]); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 2'd0) |-> (paddr == 32'h0 && perm == 3'h0)); // R10
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (done),
    .fault         (fault),
    .paddr         (paddr),
    .perm          (perm)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    localparam logic [31:0] ROOT_A = 32'h0010_0000;
    localparam logic [31:0] ROOT_B = 32'h0020_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        root_we = 1'b0;
    logic [31:0] root_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [1:0]  fault;
    logic [31:0] paddr;
    logic [2:0]  perm;
    logic [1:0]  res_kind;

    int checks = 0;
    int failures = 0;
    int rd_cnt = 0;
    logic [31:0] rd_addr [2];
    logic [31:0] cur_root = '0;

    always #4 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst(rst), .root_we(root_we), .root_wdata(root_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
        .fault(fault), .paddr(paddr), .perm(perm), .res_kind(res_kind)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] h;
        logic [9:0]  ix;
        if (a[31:12] == 20'h00100 || a[31:12] == 20'h00200) begin
            ix = a[11:2];
            return {(a[21] ? 20'h00800 : 20'h00400) + {10'h0, ix}, 8'hA5, 3'b000,
                    ix[2:0] != 3'd6};
        end
        h = (a * 32'h9E37_79B1) ^ (a >> 7);
        return {h[31:1], a[4:2] != 3'd5};
    endfunction

    task automatic model(input logic [31:0] root, input logic [31:0] va,
                         output logic [1:0] f, output logic [31:0] pa,
                         output logic [2:0] pm, output logic [31:0] a1,
                         output logic [31:0] a2);
        logic [31:0] e1, e2;
        a1 = root + {20'h0, va[31:22], 2'b00};
        e1 = mem_word(a1);
        a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
        e2 = mem_word(a2);
        if (!e1[0])      begin f = 2'd1; pa = '0; pm = '0; end
        else if (!e2[0]) begin f = 2'd2; pa = '0; pm = '0; end
        else begin f = 2'd0; pa = {e2[31:12], va[11:0]}; pm = e2[3:1]; end
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: answers each read after 1..3 cycles (R9)
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                logic [31:0] a;
                a = mem_req_addr;
                if (rd_cnt < 2) rd_addr[rd_cnt] = a;
                rd_cnt++;
                repeat (1 + $urandom % 3) @(negedge clk);
                mem_rsp_data  = mem_word(a);
                mem_rsp_valid = 1'b1;
            end
        end
    end

    task automatic set_root(input logic [31:0] v);
        @(negedge clk);
        root_we = 1'b1; root_wdata = v;
        @(negedge clk);
        root_we = 1'b0;
        cur_root = v;
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] kind,
                        input bit poke, input bit swap, input logic [31:0] nroot);
        logic [1:0] ef; logic [31:0] ep, a1, a2; logic [2:0] em;
        int n;
        model(cur_root, va, ef, ep, em, a1, a2);
        @(negedge clk);
        rd_cnt = 0;
        check(req_ready == 1'b1, "R2 ready when idle", {31'h0, req_ready}, 32'h1);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        if (swap) begin root_we = 1'b1; root_wdata = nroot; end
        @(negedge clk);
        req_valid = poke; req_vaddr = ~va; root_we = 1'b0;
        if (swap) cur_root = nroot;
        check(req_ready == 1'b0, "R2 busy", {31'h0, req_ready}, 32'h0);
        if (poke) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 100) begin @(negedge clk); n++; end
        check(done == 1'b1, "R9 walk completes", {31'h0, done}, 32'h1);
        check(fault == ef, "R5/R6 fault code", {30'h0, fault}, {30'h0, ef});
        check(paddr == ep, "R7 paddr", paddr, ep);
        check(perm == em, "R7 perm", {29'h0, perm}, {29'h0, em});
        check(res_kind == kind, "R10 kind echo", {30'h0, res_kind}, {30'h0, kind});
        check(rd_addr[0] == a1, "R3 directory address", rd_addr[0], a1);
        if (ef == 2'd1) begin
            check(rd_cnt == 1, "R5 single read", rd_cnt, 1);
        end else begin
            check(rd_cnt == 2, "R6 two reads", rd_cnt, 2);
            check(rd_addr[1] == a2, "R4 leaf address", rd_addr[1], a2);
        end
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", {31'h0, done}, 32'h0);
        check(rd_cnt <= 2, "R2 no second walk", rd_cnt, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", {31'h0, req_ready}, 32'h1);
        check(done == 1'b0, "R1 done after reset", {31'h0, done}, 32'h0);
        check(mem_req_valid == 1'b0, "R1 no read after reset", {31'h0, mem_req_valid}, 32'h0);

        set_root(ROOT_A);
        // R11 split of the self-check address
        walk(32'h05EA_E864, 2'd1, 1'b0, 1'b0, '0);
        check(rd_addr[0] == 32'h0010_005C, "R11 directory index 0x017", rd_addr[0], 32'h0010_005C);
        check(rd_addr[1] == 32'h0041_7AB8, "R11 leaf index 0x2AE", rd_addr[1], 32'h0041_7AB8);
        check(paddr[11:0] == 12'h864, "R11 offset 0x864", {20'h0, paddr[11:0]}, 32'h864);
        // R5 directory entry absent (index low bits 6)
        walk(32'h0180_0ABC, 2'd2, 1'b0, 1'b0, '0);
        // R6 leaf absent (leaf index low bits 5)
        walk(32'h0040_5123, 2'd3, 1'b0, 1'b0, '0);
        // R2 request held during a walk
        walk(32'h1234_5678, 2'd0, 1'b1, 1'b0, '0);
        // R8 root written in the accepting cycle; this walk keeps ROOT_A
        walk(32'h05EA_E864, 2'd1, 1'b0, 1'b1, ROOT_B);
        check(rd_addr[0] == 32'h0010_005C, "R8 old root kept", rd_addr[0], 32'h0010_005C);
        walk(32'h05EA_E864, 2'd1, 1'b0, 1'b0, '0);
        check(rd_addr[0] == 32'h0020_005C, "R8 new root used", rd_addr[0], 32'h0020_005C);

        for (int i = 0; i < 60; i++) begin
            if (i % 7 == 3) set_root((cur_root == ROOT_A) ? ROOT_B : ROOT_A);
            walk($urandom, 2'($urandom), 1'($urandom), 1'b0, '0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule